// File: doc/BRIEF.md
# Shared Packet RAM Arbiter

This block owns a single-port packet RAM and shares it between two clients. The first client is the host. It moves 16-bit words through two sequential-access windows. Each window keeps its own auto-incrementing byte pointer, so the host sets an address once and then streams words without giving an address on every access. The second client is the internal DMA port that feeds the MAC data path. It gives a word address on every request and always gets the RAM in the cycle it asks for it.

The host never waits. A host write drops into a one-word buffer. Each window keeps a prefetch register that already holds the word at its pointer. The buffer and the prefetch registers are serviced in cycles that the DMA port leaves idle. A write from either port to a word that sits in a prefetch register discards that register, and the word is fetched again, so a host read always returns current data. Register accesses other than RAM traffic do not pass through this block.

Top module: `pkt_ram_arbiter`

## Requirements
- R1: After reset, `dma_rvalid` is low, both window pointers are byte 0 and the write buffer is empty.
- R2: A DMA request is served in the same cycle, ahead of any host work. A read returns `dma_rdata` with `dma_rvalid` high exactly one cycle after the request. A write updates the word at that clock edge.
- R3: `host_load` sets the pointer of the window chosen by `host_win` (0 or 1) from the byte address `host_addr`. Bit 0 of that address is ignored.
- R4: Each host read or write through a window advances that window's pointer by 2 bytes. After the last word (byte DEPTH_BYTES-2), the pointer wraps to byte 0.
- R5: The two windows keep separate pointers and prefetch registers. A load, read or write on one window leaves the other window's pointer unchanged.
- R6: A host write is captured in the same cycle and committed in the first later cycle with no DMA request. A host write that coincides with a DMA request is still committed.
- R7: While `host_rd` is high, `host_rdata` is the word at the selected window's pointer, with no wait state. This holds when DMA never requests in two consecutive cycles and host accesses are at least 8 cycles apart.
- R8: A host read returns the latest value written before it by either port. This includes a write through the other window and a DMA write to a word that was already prefetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_win | input | 1 | Window selected by the host access |
| host_load | input | 1 | Load the selected window pointer |
| host_addr | input | BAW (13) | Byte address for a pointer load |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write word |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Word at the selected window pointer |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | AW (12) | DMA word address |
| dma_wdata | input | 16 | DMA write word |
| dma_rdata | output | 16 | DMA read word |
| dma_rvalid | output | 1 | DMA read data valid |

## Verification
The bench runs full-RAM sweeps while background DMA reads take every other cycle. Hidden stalls therefore have to be absorbed. A design that let the host lose a write slot, or that serviced a prefetch late, returns words shifted by one position. Pointer wrap is checked in both the write and the read direction. An off-by-one at the top of the RAM shows up as a stray word at address 0. Coherence is tested with a write through the other window and with a DMA write to a word that is already prefetched. A design that never invalidates its prefetch returns the stale value. A host write issued in the same cycle as a DMA read checks that the DMA keeps priority and that the host word is still committed afterwards.

// File: rtl/pkt_ram_arbiter.sv
module pkt_ram_arbiter #(
  parameter int DEPTH_BYTES = 4608,
  parameter int DW          = 16,
  localparam int BPW        = DW / 8,
  localparam int WORDS      = DEPTH_BYTES / BPW,
  localparam int AW         = $clog2(WORDS),
  localparam int BAW        = AW + $clog2(BPW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_win,
  input  logic          host_load,
  input  logic [BAW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          dma_req,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  output logic [DW-1:0] dma_rdata,
  output logic          dma_rvalid
);

  logic [DW-1:0]  mem [WORDS];
  logic [BAW-1:0] ptr [2];
  logic [DW-1:0]  pf_data [2];
  logic [1:0]     pf_vld;
  logic           wb_full;
  logic [BAW-1:0] wb_addr;
  logic [DW-1:0]  wb_data;

  function automatic logic [AW-1:0] widx(input logic [BAW-1:0] p);
    return AW'(p >> $clog2(BPW));
  endfunction

  function automatic logic [BAW-1:0] nxt(input logic [BAW-1:0] p);
    return (p >= BAW'(DEPTH_BYTES - BPW)) ? '0 : p + BAW'(BPW);
  endfunction

  wire free      = !dma_req;
  wire do_commit = free && wb_full;
  wire do_pf0    = free && !wb_full && !pf_vld[0];
  wire do_pf1    = free && !wb_full && pf_vld[0] && !pf_vld[1];
  wire pf_sel    = do_pf1;
  wire do_pf     = do_pf0 || do_pf1;

  assign host_rdata = pf_data[host_win];

  always_ff @(posedge clk) begin
    if (dma_req) begin
      if (dma_we) mem[dma_addr] <= dma_wdata;
      else        dma_rdata     <= mem[dma_addr];
    end else if (do_commit) begin
      mem[widx(wb_addr)] <= wb_data;
    end else if (do_pf) begin
      pf_data[pf_sel] <= mem[widx(ptr[pf_sel])];
    end
    if (host_wr && !wb_full) begin
      wb_addr <= ptr[host_win];
      wb_data <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr[0]     <= '0;
      ptr[1]     <= '0;
      pf_vld     <= '0;
      wb_full    <= 1'b0;
      dma_rvalid <= 1'b0;
    end else begin
      dma_rvalid <= dma_req && !dma_we;
      if (do_commit) wb_full <= 1'b0;
      if (host_wr)   wb_full <= 1'b1;
      if (do_pf)     pf_vld[pf_sel] <= 1'b1;
      for (int w = 0; w < 2; w++) begin
        if (do_commit && pf_vld[w] && ptr[w] == wb_addr)
          pf_vld[w] <= 1'b0;
        if (dma_req && dma_we && pf_vld[w] && widx(ptr[w]) == dma_addr)
          pf_vld[w] <= 1'b0;
        if (host_win == 1'(w)) begin
          if (host_load) begin
            ptr[w]    <= host_addr & ~BAW'(BPW - 1);
            pf_vld[w] <= 1'b0;
          end else if (host_rd || host_wr) begin
            ptr[w]    <= nxt(ptr[w]);
            pf_vld[w] <= 1'b0;
          end
        end
      end
    end
  end

  assert_rd_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |-> pf_vld[host_win]);

  assert_wr_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |-> !wb_full);

  assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_full && !dma_req) |=> !wb_full);

  assert_dma_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_we) |=> dma_rvalid);

  assert_dma_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && !dma_we) |=> !dma_rvalid);

  assert_one_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({host_load, host_rd, host_wr}) <= 1);

endmodule

// File: tb/test_pkt_ram_arbiter.sv
module test_pkt_ram_arbiter;
  localparam int DEPTH = 4608;
  localparam int WORDS = DEPTH / 2;
  localparam int AW = 12;
  localparam int BAW = 13;

  logic clk = 0, rst_n = 0;
  logic host_win = 0, host_load = 0, host_wr = 0, host_rd = 0;
  logic [BAW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic dma_req = 0, dma_we = 0;
  logic [AW-1:0] dma_addr = '0;
  logic [15:0] dma_wdata = '0, dma_rdata;
  logic dma_rvalid;

  int tests = 0, fails = 0;
  bit bg = 0, phase = 0;
  int bg_addr = 0;
  logic [15:0] exp_mem [WORDS];

  always #5 clk = ~clk;

  pkt_ram_arbiter i_pkt_ram_arbiter (
    .clk(clk), .rst_n(rst_n), .host_win(host_win), .host_load(host_load),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .dma_req(dma_req),
    .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .dma_rvalid(dma_rvalid));

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    host_load = 0; host_rd = 0; host_wr = 0;
    if (bg) begin
      phase = !phase;
      dma_req = phase; dma_we = 0; dma_addr = AW'(bg_addr);
      if (phase) bg_addr = (bg_addr == WORDS - 1) ? 0 : bg_addr + 1;
    end else dma_req = 0;
  endtask

  task automatic gap();
    repeat (7) step();
  endtask

  task automatic hload(input bit w, input int baddr);
    step(); host_win = w; host_load = 1; host_addr = BAW'(baddr);
    gap();
  endtask

  task automatic hwrite(input bit w, input logic [15:0] d);
    step(); host_win = w; host_wr = 1; host_wdata = d;
    gap();
  endtask

  task automatic hread(input bit w, input logic [15:0] e, input string req);
    step(); host_win = w; host_rd = 1;
    #1 chk(host_rdata === e, req, {16'h0, host_rdata}, {16'h0, e});
    gap();
  endtask

  task automatic dwrite(input int a, input logic [15:0] d);
    step(); dma_req = 1; dma_we = 1; dma_addr = AW'(a); dma_wdata = d;
    step();
    exp_mem[a] = d;
  endtask

  task automatic dread(input int a, input string req);
    step(); dma_req = 1; dma_we = 0; dma_addr = AW'(a);
    step();
    chk(dma_rvalid === 1'b1 && dma_rdata === exp_mem[a], req,
        {15'h0, dma_rvalid, dma_rdata}, {16'h1, exp_mem[a]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dma_rvalid === 1'b0, "R1", {31'h0, dma_rvalid}, 32'h0);
    rst_n = 1;
    step();
    chk(dma_rvalid === 1'b0, "R1", {31'h0, dma_rvalid}, 32'h0);
    gap();
    // R8: both windows prefetched word 0 after reset, then DMA overwrites it
    dwrite(0, 16'h1234);
    gap();
    hread(0, 16'h1234, "R1");
    hread(1, 16'h1234, "R8");

    // Full sweep through window 0 with background DMA contention
    bg = 1;
    hload(0, 0);
    for (int i = 0; i < WORDS; i++) begin
      hwrite(0, pat(i));
      exp_mem[i] = pat(i);
    end
    hwrite(0, 16'hBEEF);  // R4: wrapped to word 0
    exp_mem[0] = 16'hBEEF;

    hload(1, 0);
    for (int i = 0; i < WORDS; i++)
      hread(1, exp_mem[i], (i == 0) ? "R4" : "R7");
    bg = 0;
    gap();

    // R2: DMA readback of the whole RAM
    for (int i = 0; i < WORDS; i++) dread(i, "R2");
    dwrite(5, 16'hA5A5);
    dread(5, "R2");

    // R3: odd byte address loads the containing word
    hload(0, 2 * 100 + 1);
    hread(0, exp_mem[100], "R3");
    hread(0, exp_mem[101], "R4");

    // R5: independent windows
    hload(0, 2 * 10);
    hload(1, 2 * 20);
    hread(0, exp_mem[10], "R5");
    hread(1, exp_mem[20], "R5");
    hread(0, exp_mem[11], "R5");
    hread(1, exp_mem[21], "R5");

    // R8: write through window 0 to the word window 1 has prefetched (22)
    hload(0, 2 * 22);
    hwrite(0, 16'hC0DE);
    exp_mem[22] = 16'hC0DE;
    hread(1, 16'hC0DE, "R8");

    // R6: host write coinciding with a DMA read
    hload(0, 2 * 300);
    step(); host_win = 0; host_wr = 1; host_wdata = 16'h7E57;
    dma_req = 1; dma_we = 0; dma_addr = AW'(7);
    step();
    chk(dma_rvalid === 1'b1 && dma_rdata === exp_mem[7], "R2",
        {15'h0, dma_rvalid, dma_rdata}, {16'h1, exp_mem[7]});
    exp_mem[300] = 16'h7E57;
    gap();
    hload(1, 2 * 300);
    hread(1, 16'h7E57, "R6");
    dread(300, "R6");

    // R4: read wrap at the top of the RAM
    hload(1, DEPTH - 2);
    hread(1, exp_mem[WORDS-1], "R4");
    hread(1, exp_mem[0], "R4");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule